// File: doc/BRIEF.md
# Multi-Bank DRAM Command Timing Guard

This block sits on the controller side of a four-bank synchronous DRAM and decides, clock by clock, whether the command being requested may legally go out on the current cycle. It does not schedule or queue anything. It looks at one request (command code, bank number, auto-precharge flag) and answers with a combinational grant. A request that is granted counts as issued on the next rising edge. On that same edge the block updates its record of which banks hold an open row and reloads the countdowns that the command starts.

Each bank keeps an open/idle flag and four countdowns:
- earliest next activate,
- earliest read after activate,
- earliest write after activate,
- earliest precharge.

Device-wide countdowns cover:
- activate-to-activate spacing across banks,
- column-to-column spacing,
- the write-to-read turnaround,
- the quiet period after refresh or mode programming.

A separate interval counter raises a refresh-due flag. All spacings are parameters counted in clock cycles. A spacing of N means the next qualifying command may be granted N cycles after the one that started it.

Top module: `dram_timing_guard`

## Requirements
- R1: After reset no bank is open, every countdown is clear and refresh_due is low. The first activate to any bank is granted at once.
- R2: Command code 3'd1 (activate) is granted only to an idle bank whose own activate countdown has expired. Activates to any two banks are at least T_RRD cycles apart.
- R3: Code 3'd2 (read) to a bank is granted no earlier than T_RCD_RD cycles after its activate. Code 3'd3 (write) is granted no earlier than T_RCD_WR cycles after its activate.
- R4: Reads and writes to an idle bank are refused. Successive column commands are at least T_CCD cycles apart.
- R5: Code 3'd4 (precharge one bank) waits T_RAS cycles after that bank's activate, and waits for read or write recovery. Code 3'd5 (precharge all) is granted only when every bank meets that condition.
- R6: After a write, no read is granted for T_BURST + T_CDLR cycles, so a read never interrupts a write burst.
- R7: A read or write issued with req_autopre high closes its bank. The bank may be activated again T_BURST + T_RP cycles after the read, or T_BURST + T_DAL cycles after the write, unless its row-cycle countdown ends later.
- R8: Code 3'd6 (auto refresh) is granted only when all banks are idle and every bank's activate countdown has expired. No command is granted for T_RFC cycles after it.
- R9: Code 3'd7 (mode register set) has the same all-idle condition. No command is granted for T_MRD cycles after it.
- R10: refresh_due rises T_REFI cycles after reset or after the last granted refresh. It stays high until a refresh is granted.
- R11: Grant is low whenever req_valid is low or the code is 3'd0. A withheld request is not remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A command is being requested this cycle |
| req_cmd | input | 3 | Command code (see requirements) |
| req_bank | input | BANK_W | Target bank for activate, read, write, precharge |
| req_autopre | input | 1 | Close the bank after this read or write |
| grant | output | 1 | The request may issue; it takes effect at the next edge |
| refresh_due | output | 1 | The refresh interval has elapsed |

## Verification
The bench keeps every spacing at its default, the 200 MHz grade values. With these defaults the exact edge cases are reachable:
- activate-to-read of 4 against activate-to-write of 2,
- the 8-cycle row-active minimum,
- the 2+2 write-to-read gap,
- the 2+6 and 2+4 auto-precharge gaps,
- the 14-cycle refresh blackout.

Each is hit one cycle early and exactly on time. Only the refresh interval is cut from 1560 to 64 cycles. This lets the rise and hold of refresh_due, and its clearing by a refresh, be seen within a short run.

// File: rtl/dram_guard_pkg.sv
package dram_guard_pkg;

    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_PREA = 3'd5,
        CMD_REF  = 3'd6,
        CMD_MRS  = 3'd7
    } dram_cmd_e;

    // events that one bank sees on an issuing edge
    typedef struct packed {
        logic act;
        logic rd;
        logic wr;
        logic pre;
        logic ap;
    } bank_ev_t;

    // what one bank reports back to the grant logic
    typedef struct packed {
        logic open;
        logic act_ok;
        logic rd_ok;
        logic wr_ok;
        logic pre_ok;
    } bank_st_t;

    // a spacing of n cycles becomes a countdown load of n-1
    function automatic int unsigned gap_to_load(input int unsigned n);
        return (n == 0) ? 0 : n - 1;
    endfunction

endpackage

// File: rtl/dram_bank_timer.sv
module dram_bank_timer
    import dram_guard_pkg::*;
#(
    parameter int unsigned CW       = 6,
    parameter int unsigned T_RC     = 12,
    parameter int unsigned T_RAS    = 8,
    parameter int unsigned T_RP     = 4,
    parameter int unsigned T_RCD_RD = 4,
    parameter int unsigned T_RCD_WR = 2,
    parameter int unsigned T_WR     = 2,
    parameter int unsigned T_DAL    = 6,
    parameter int unsigned T_BURST  = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  bank_ev_t ev,
    output bank_st_t st
);

    localparam logic [CW-1:0] L_RC    = CW'(gap_to_load(T_RC));
    localparam logic [CW-1:0] L_RAS   = CW'(gap_to_load(T_RAS));
    localparam logic [CW-1:0] L_RP    = CW'(gap_to_load(T_RP));
    localparam logic [CW-1:0] L_RCDR  = CW'(gap_to_load(T_RCD_RD));
    localparam logic [CW-1:0] L_RCDW  = CW'(gap_to_load(T_RCD_WR));
    localparam logic [CW-1:0] L_RDPRE = CW'(gap_to_load(T_BURST));
    localparam logic [CW-1:0] L_WRPRE = CW'(gap_to_load(T_BURST + T_WR));
    localparam logic [CW-1:0] L_RDAP  = CW'(gap_to_load(T_BURST + T_RP));
    localparam logic [CW-1:0] L_WRAP  = CW'(gap_to_load(T_BURST + T_DAL));

    logic          open_q;
    logic [CW-1:0] act_q, rd_q, wr_q, pre_q;

    function automatic logic [CW-1:0] dec(input logic [CW-1:0] x);
        return (x == '0) ? '0 : x - 1'b1;
    endfunction

    function automatic logic [CW-1:0] maxv(input logic [CW-1:0] a, input logic [CW-1:0] b);
        return (a > b) ? a : b;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            act_q  <= '0;
            rd_q   <= '0;
            wr_q   <= '0;
            pre_q  <= '0;
        end else begin
            act_q <= dec(act_q);
            rd_q  <= dec(rd_q);
            wr_q  <= dec(wr_q);
            pre_q <= dec(pre_q);
            if (ev.act) begin
                open_q <= 1'b1;
                act_q  <= L_RC;
                rd_q   <= L_RCDR;
                wr_q   <= L_RCDW;
                pre_q  <= L_RAS;
            end
            if (ev.rd) begin
                pre_q <= maxv(dec(pre_q), L_RDPRE);
                if (ev.ap) begin
                    open_q <= 1'b0;
                    act_q  <= maxv(dec(act_q), L_RDAP);
                end
            end
            if (ev.wr) begin
                pre_q <= maxv(dec(pre_q), L_WRPRE);
                if (ev.ap) begin
                    open_q <= 1'b0;
                    act_q  <= maxv(dec(act_q), L_WRAP);
                end
            end
            if (ev.pre && open_q) begin
                open_q <= 1'b0;
                act_q  <= maxv(dec(act_q), L_RP);
            end
        end
    end

    always_comb begin
        st.open   = open_q;
        st.act_ok = (act_q == '0);
        st.rd_ok  = (rd_q == '0);
        st.wr_ok  = (wr_q == '0);
        st.pre_ok = (pre_q == '0);
    end

    // R2: an activate only ever reaches a closed bank whose cycle has ended
    p_act_closed_r2: assert property (@(posedge clk) disable iff (rst)
        ev.act |-> (!open_q && act_q == '0))
        else $error("activate reached an open or busy bank");

    // R3: a read cannot follow its activate on the very next cycle
    p_rcd_rd_r3: assert property (@(posedge clk) disable iff (rst)
        (ev.act && T_RCD_RD > 1) |=> !st.rd_ok)
        else $error("read window opened too early");

    // R4: column commands only reach an open bank
    p_col_open_r4: assert property (@(posedge clk) disable iff (rst)
        (ev.rd || ev.wr) |-> open_q)
        else $error("column command to idle bank");

    // R7: auto-precharge leaves the bank idle afterwards
    p_ap_close_r7: assert property (@(posedge clk) disable iff (rst)
        ((ev.rd || ev.wr) && ev.ap) |=> !open_q)
        else $error("auto-precharge did not close bank");

endmodule

// File: rtl/dram_dev_timer.sv
module dram_dev_timer
    import dram_guard_pkg::*;
#(
    parameter int unsigned CW      = 6,
    parameter int unsigned T_RRD   = 2,
    parameter int unsigned T_CCD   = 1,
    parameter int unsigned T_BURST = 2,
    parameter int unsigned T_CDLR  = 2,
    parameter int unsigned T_RFC   = 14,
    parameter int unsigned T_MRD   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ev_act,
    input  logic ev_rd,
    input  logic ev_wr,
    input  logic ev_ref,
    input  logic ev_mrs,
    output logic act_ok,
    output logic col_ok,
    output logic wtr_ok,
    output logic quiet_ok
);

    localparam logic [CW-1:0] L_RRD = CW'(gap_to_load(T_RRD));
    localparam logic [CW-1:0] L_CCD = CW'(gap_to_load(T_CCD));
    localparam logic [CW-1:0] L_WTR = CW'(gap_to_load(T_BURST + T_CDLR));
    localparam logic [CW-1:0] L_RFC = CW'(gap_to_load(T_RFC));
    localparam logic [CW-1:0] L_MRD = CW'(gap_to_load(T_MRD));

    logic [CW-1:0] rrd_q, ccd_q, wtr_q, busy_q;

    function automatic logic [CW-1:0] dec(input logic [CW-1:0] x);
        return (x == '0) ? '0 : x - 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rrd_q  <= '0;
            ccd_q  <= '0;
            wtr_q  <= '0;
            busy_q <= '0;
        end else begin
            rrd_q  <= ev_act ? L_RRD : dec(rrd_q);
            ccd_q  <= (ev_rd || ev_wr) ? L_CCD : dec(ccd_q);
            wtr_q  <= ev_wr ? L_WTR : dec(wtr_q);
            if (ev_ref)      busy_q <= L_RFC;
            else if (ev_mrs) busy_q <= L_MRD;
            else             busy_q <= dec(busy_q);
        end
    end

    assign act_ok   = (rrd_q == '0);
    assign col_ok   = (ccd_q == '0);
    assign wtr_ok   = (wtr_q == '0);
    assign quiet_ok = (busy_q == '0);

    // R2: back-to-back activates across banks are held apart
    p_rrd_r2: assert property (@(posedge clk) disable iff (rst)
        (ev_act && T_RRD > 1) |=> !act_ok)
        else $error("activate spacing not enforced");

    // R6: a write shuts the read window on the next cycle
    p_wtr_r6: assert property (@(posedge clk) disable iff (rst)
        (ev_wr && (T_BURST + T_CDLR) > 1) |=> !wtr_ok)
        else $error("read allowed inside write burst");

    // R8: refresh starts a quiet period
    p_rfc_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (ev_ref && T_RFC > 1) |=> !quiet_ok)
        else $error("no quiet period after refresh");

    // R9: mode programming starts a quiet period
    p_mrd_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (ev_mrs && T_MRD > 1) |=> !quiet_ok)
        else $error("no quiet period after mode set");

endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int unsigned T_REFI = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic ev_ref,
    output logic due
);

    localparam int unsigned RW = $clog2(T_REFI + 1);
    localparam logic [RW-1:0] L_REFI = RW'(T_REFI - 1);

    logic [RW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || ev_ref)       cnt_q <= L_REFI;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign due = (cnt_q == '0);

    // R10: once raised the flag holds until a refresh goes out
    p_due_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (due && !ev_ref) |=> due)
        else $error("refresh_due dropped without refresh");

    // R10: a refresh clears the flag
    p_due_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (ev_ref && T_REFI > 1) |=> !due)
        else $error("refresh_due not cleared");

endmodule

// File: rtl/dram_timing_guard.sv
module dram_timing_guard
    import dram_guard_pkg::*;
#(
    parameter int unsigned BANK_W   = 2,
    parameter int unsigned T_RCD_RD = 4,
    parameter int unsigned T_RCD_WR = 2,
    parameter int unsigned T_RAS    = 8,
    parameter int unsigned T_RP     = 4,
    parameter int unsigned T_RC     = 12,
    parameter int unsigned T_RRD    = 2,
    parameter int unsigned T_CCD    = 1,
    parameter int unsigned T_RFC    = 14,
    parameter int unsigned T_DAL    = 6,
    parameter int unsigned T_WR     = 2,
    parameter int unsigned T_CDLR   = 2,
    parameter int unsigned T_MRD    = 2,
    parameter int unsigned T_BURST  = 2,
    parameter int unsigned T_REFI   = 1560
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_cmd,
    input  logic [BANK_W-1:0] req_bank,
    input  logic              req_autopre,
    output logic              grant,
    output logic              refresh_due
);

    localparam int unsigned NUM_BANKS = 1 << BANK_W;
    localparam int unsigned CW = $clog2(T_RC + T_RAS + T_RFC + T_BURST + T_DAL + T_CDLR + T_MRD + 2);

    dram_cmd_e             cmd;
    logic                  allowed;
    logic                  issue;
    bank_ev_t              bev  [NUM_BANKS];
    bank_st_t              bst  [NUM_BANKS];
    logic [NUM_BANKS-1:0]  open_v, act_v, rd_v, wr_v, pre_v;
    logic                  d_act_ok, d_col_ok, d_wtr_ok, d_quiet;
    logic                  is_act, is_rd, is_wr, is_ref, is_mrs;

    assign cmd   = dram_cmd_e'(req_cmd);
    assign issue = req_valid && allowed;
    assign grant = issue;

    assign is_act = issue && (cmd == CMD_ACT);
    assign is_rd  = issue && (cmd == CMD_RD);
    assign is_wr  = issue && (cmd == CMD_WR);
    assign is_ref = issue && (cmd == CMD_REF);
    assign is_mrs = issue && (cmd == CMD_MRS);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (req_bank == BANK_W'(b));

        always_comb begin
            bev[b].act = is_act && hit;
            bev[b].rd  = is_rd && hit;
            bev[b].wr  = is_wr && hit;
            bev[b].pre = issue && ((cmd == CMD_PRE && hit) || cmd == CMD_PREA);
            bev[b].ap  = req_autopre;
        end

        dram_bank_timer #(
            .CW(CW), .T_RC(T_RC), .T_RAS(T_RAS), .T_RP(T_RP),
            .T_RCD_RD(T_RCD_RD), .T_RCD_WR(T_RCD_WR), .T_WR(T_WR),
            .T_DAL(T_DAL), .T_BURST(T_BURST)
        ) u_bank (
            .clk(clk), .rst(rst), .ev(bev[b]), .st(bst[b])
        );

        assign open_v[b] = bst[b].open;
        assign act_v[b]  = bst[b].act_ok;
        assign rd_v[b]   = bst[b].rd_ok;
        assign wr_v[b]   = bst[b].wr_ok;
        assign pre_v[b]  = bst[b].pre_ok;
    end

    dram_dev_timer #(
        .CW(CW), .T_RRD(T_RRD), .T_CCD(T_CCD), .T_BURST(T_BURST),
        .T_CDLR(T_CDLR), .T_RFC(T_RFC), .T_MRD(T_MRD)
    ) u_dev (
        .clk(clk), .rst(rst),
        .ev_act(is_act), .ev_rd(is_rd), .ev_wr(is_wr),
        .ev_ref(is_ref), .ev_mrs(is_mrs),
        .act_ok(d_act_ok), .col_ok(d_col_ok), .wtr_ok(d_wtr_ok), .quiet_ok(d_quiet)
    );

    dram_refresh_timer #(.T_REFI(T_REFI)) u_refi (
        .clk(clk), .rst(rst), .ev_ref(is_ref), .due(refresh_due)
    );

    always_comb begin
        allowed = 1'b0;
        unique case (cmd)
            CMD_ACT:  allowed = !open_v[req_bank] && act_v[req_bank] && d_act_ok;
            CMD_RD:   allowed = open_v[req_bank] && rd_v[req_bank] && d_col_ok && d_wtr_ok;
            CMD_WR:   allowed = open_v[req_bank] && wr_v[req_bank] && d_col_ok;
            CMD_PRE:  allowed = pre_v[req_bank];
            CMD_PREA: allowed = &pre_v;
            CMD_REF,
            CMD_MRS:  allowed = !(|open_v) && (&act_v);
            default:  allowed = 1'b0;
        endcase
        allowed = allowed && d_quiet;
    end

    // R11: nothing issues without a request
    p_grant_req_r11: assert property (@(posedge clk) disable iff (rst)
        grant |-> (req_valid && req_cmd != 3'd0))
        else $error("grant without request");

    // R8: a granted refresh finds every bank closed
    p_ref_idle_r8: assert property (@(posedge clk) disable iff (rst)
        is_ref |-> (open_v == '0))
        else $error("refresh with open bank");

endmodule

// File: tb/dram_timing_guard_tb_top.sv
module dram_timing_guard_tb_top;
    import dram_guard_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       v;
        logic [2:0] cmd;
        logic [1:0] bank;
        logic       ap;
        logic       exp;
        logic [3:0] req;
        logic [4:0] n;
    } row_t;

    localparam int NROWS = 27;
    localparam row_t TBL [NROWS] = '{
        '{1'b1, CMD_ACT,  2'd0, 1'b0, 1'b1, 4'd2,  5'd1},  // c0  R2 first activate
        '{1'b1, CMD_ACT,  2'd1, 1'b0, 1'b0, 4'd2,  5'd1},  // c1  R2 T_RRD
        '{1'b1, CMD_ACT,  2'd1, 1'b0, 1'b1, 4'd2,  5'd1},  // c2  R2
        '{1'b1, CMD_RD,   2'd0, 1'b0, 1'b0, 4'd3,  5'd1},  // c3  R3 one early
        '{1'b1, CMD_RD,   2'd0, 1'b0, 1'b1, 4'd3,  5'd1},  // c4  R3 exact
        '{1'b1, CMD_WR,   2'd1, 1'b0, 1'b1, 4'd3,  5'd1},  // c5  R3 write after 3
        '{1'b1, CMD_RD,   2'd0, 1'b0, 1'b0, 4'd6,  5'd1},  // c6  R6
        '{1'b1, CMD_PRE,  2'd0, 1'b0, 1'b0, 4'd5,  5'd1},  // c7  R5 T_RAS one early
        '{1'b1, CMD_RD,   2'd0, 1'b0, 1'b0, 4'd6,  5'd1},  // c8  R6 one early
        '{1'b1, CMD_RD,   2'd0, 1'b1, 1'b1, 4'd6,  5'd1},  // c9  R6 exact, autopre
        '{1'b1, CMD_ACT,  2'd0, 1'b0, 1'b0, 4'd7,  5'd1},  // c10 R7
        '{1'b1, CMD_WR,   2'd1, 1'b1, 1'b1, 4'd7,  5'd1},  // c11 R7 write autopre
        '{1'b1, CMD_REF,  2'd0, 1'b0, 1'b0, 4'd8,  5'd1},  // c12 R8 countdowns pending
        '{1'b1, CMD_WR,   2'd0, 1'b0, 1'b0, 4'd4,  5'd1},  // c13 R4 idle bank
        '{1'b1, CMD_ACT,  2'd0, 1'b0, 1'b0, 4'd7,  5'd1},  // c14 R7 one early
        '{1'b1, CMD_ACT,  2'd0, 1'b0, 1'b1, 4'd7,  5'd1},  // c15 R7 exact
        '{1'b1, CMD_PREA, 2'd0, 1'b0, 1'b0, 4'd5,  5'd1},  // c16 R5
        '{1'b0, CMD_NONE, 2'd0, 1'b0, 1'b0, 4'd11, 5'd6},  // c17-22 R11
        '{1'b1, CMD_PREA, 2'd0, 1'b0, 1'b1, 4'd5,  5'd1},  // c23 R5 exact
        '{1'b1, CMD_MRS,  2'd0, 1'b0, 1'b0, 4'd9,  5'd1},  // c24 R9 T_RP pending
        '{1'b0, CMD_NONE, 2'd0, 1'b0, 1'b0, 4'd11, 5'd2},  // c25-26 R11
        '{1'b1, CMD_REF,  2'd0, 1'b0, 1'b1, 4'd8,  5'd1},  // c27 R8 granted
        '{1'b1, CMD_ACT,  2'd1, 1'b0, 1'b0, 4'd8,  5'd1},  // c28 R8 blackout
        '{1'b0, CMD_NONE, 2'd0, 1'b0, 1'b0, 4'd11, 5'd11}, // c29-39 R11
        '{1'b1, CMD_ACT,  2'd1, 1'b0, 1'b0, 4'd8,  5'd1},  // c40 R8 one early
        '{1'b1, CMD_ACT,  2'd1, 1'b0, 1'b1, 4'd8,  5'd1},  // c41 R8 exact
        '{1'b1, CMD_MRS,  2'd0, 1'b0, 1'b0, 4'd9,  5'd1}   // c42 R9 bank open
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_cmd = 3'd0;
    logic [1:0] req_bank = 2'd0;
    logic       req_autopre = 1'b0;
    logic       grant, refresh_due;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_timing_guard #(.T_REFI(64)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_bank(req_bank), .req_autopre(req_autopre),
        .grant(grant), .refresh_due(refresh_due)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(input logic v, input logic [2:0] c, input logic [1:0] b, input logic ap);
        req_valid = v; req_cmd = c; req_bank = b; req_autopre = ap;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        drive(1'b0, CMD_NONE, 2'd0, 1'b0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // table walk, one row per cycle starting right after reset
        do_reset();
        for (int i = 0; i < NROWS; i++) begin
            for (int k = 0; k < int'(TBL[i].n); k++) begin
                drive(TBL[i].v, TBL[i].cmd, TBL[i].bank, TBL[i].ap);
                #1;
                chk($sformatf("R%0d row %0d", TBL[i].req, i), grant, TBL[i].exp);
                @(negedge clk);
            end
        end

        // R1: reset state, then refresh interval R10
        do_reset();
        drive(1'b0, CMD_NONE, 2'd0, 1'b0);
        #1;
        chk("R1 idle grant", grant, 1'b0);
        chk("R1 refresh_due", refresh_due, 1'b0);
        drive(1'b1, CMD_NONE, 2'd0, 1'b0);
        #1;
        chk("R11 code zero", grant, 1'b0);
        drive(1'b0, CMD_NONE, 2'd0, 1'b0);
        repeat (62) @(negedge clk);
        #1;
        chk("R10 not yet due", refresh_due, 1'b0);
        @(negedge clk);
        #1;
        chk("R10 due", refresh_due, 1'b1);
        repeat (7) @(negedge clk);
        #1;
        chk("R10 due held", refresh_due, 1'b1);
        drive(1'b1, CMD_REF, 2'd0, 1'b0);
        #1;
        chk("R8 refresh from reset", grant, 1'b1);
        @(negedge clk);
        drive(1'b1, CMD_ACT, 2'd2, 1'b0);
        #1;
        chk("R10 due cleared", refresh_due, 1'b0);
        chk("R8 blackout", grant, 1'b0);

        // R1: first activate after reset is free; R9: mode set quiet time
        do_reset();
        drive(1'b1, CMD_ACT, 2'd3, 1'b0);
        #1;
        chk("R1 first activate", grant, 1'b1);
        do_reset();
        drive(1'b1, CMD_MRS, 2'd0, 1'b0);
        #1;
        chk("R9 mode set granted", grant, 1'b1);
        @(negedge clk);
        drive(1'b1, CMD_ACT, 2'd3, 1'b0);
        #1;
        chk("R9 quiet", grant, 1'b0);
        @(negedge clk);
        #1;
        chk("R9 quiet ended", grant, 1'b1);
        @(negedge clk);
        drive(1'b1, CMD_RD, 2'd2, 1'b0);
        #1;
        chk("R4 read idle bank", grant, 1'b0);
        drive(1'b0, CMD_NONE, 2'd0, 1'b0);
        @(negedge clk);
        finish_run();
    end

endmodule